// File: doc/BRIEF.md
# Lane-Preserving Thread Block Compactor

This block regroups the active threads of one control-flow path of a thread block into the fewest dynamic warps that keep every thread in its home lane. The thread block has `NUM_WARPS` static warps of `LANES` lanes. Thread `t` (numbered from 0) belongs to static warp `t / LANES` and lane `t % LANES`. Because a thread never leaves its lane, the register-file banking of the block is unchanged. For each lane, the compactor stacks that lane's active threads into successive dynamic warps, oldest thread first. It emits one dynamic warp per cycle on a valid/ready stream.

A single-cycle `start` pulse, given once every available thread has reached the branch or reconvergence point, loads the block-wide active mask. From the next cycle the block reports how many dynamic warps the pass will produce. It then presents the warps in order, each as one thread-index slot per lane plus a lane-valid mask. After the last warp is accepted, `done` pulses for one cycle. When the mask is full, the output is the static warp arrangement, unchanged and in order.

Top module: `tbc_compactor`

## Requirements
- R1: After synchronous active-low reset, `dw_valid`, `pass_done` and `busy` are all 0.
- R2: Bit `t` of `act_mask` is thread `t`. In every emitted warp, slot `l` of `dw_tids` (bits `l*TID_W +: TID_W`) holds only a thread with `t % LANES == l`, and it carries the value `t`.
- R3: For each lane, the active threads of that lane appear in increasing thread order. The k-th emitted warp (k from 0) carries the lane's k-th active thread. A lane with no k-th thread is empty in that warp.
- R4: `dw_count` equals the largest number of active threads in any one lane. It is valid from the cycle after `start` is accepted until the next accepted `start`, and exactly that many warps are emitted.
- R5: With every thread active, warp k holds threads `k*LANES` to `k*LANES+LANES-1` in lanes 0 upward, with all lane-valid bits set.
- R6: An all-zero mask emits no warp, leaves `busy` low and raises `pass_done` in the cycle after `start`.
- R7: While `dw_valid` is high and `dw_ready` is low, `dw_valid`, `dw_tids` and `dw_lane_vld` hold their values into the next cycle.
- R8: `pass_done` is high for exactly one cycle, in the cycle after the edge that accepts the last warp, and `dw_valid` is low in that cycle.
- R9: `start` is ignored while `busy` is high: the remaining warps and `dw_count` of the pass in progress are unchanged.
- R10: Each emitted warp's lane-valid mask is a subset of the previous warp's mask within the same pass, and every emitted warp has at least one valid lane.
- R11: An empty lane has a `dw_lane_vld` bit of 0 and a thread-index slot of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | All threads have arrived; load `act_mask` (ignored while busy) |
| act_mask | input | NUM_WARPS*LANES | Block-wide active mask, bit t = thread t |
| busy | output | 1 | A pass is emitting warps |
| dw_count | output | CNT_W | Number of dynamic warps in the current pass |
| dw_valid | output | 1 | A dynamic warp is presented |
| dw_ready | input | 1 | Consumer accepts the presented warp |
| dw_tids | output | LANES*TID_W | Thread index per lane slot |
| dw_lane_vld | output | LANES | Lane-valid mask of the presented warp |
| pass_done | output | 1 | One-cycle pulse when the pass has ended |

## Verification
`dw_count` and the first warp are due in the cycle after the edge that samples `start`. Each later warp is due in the cycle after the edge on which `dw_valid` and `dw_ready` were both high. `pass_done` is due in the cycle after the last accepting edge, or in the cycle after `start` when the mask is empty. The bench drives `start`, `act_mask` and `dw_ready` on the falling edge and compares the outputs just before it drives, so each comparison falls in exactly the cycle named above. It repeats the comparison of an unchanged expected warp on every stalled cycle.

// File: rtl/tbc_pkg.sv
// Package: shared types for the thread block compactor.
// Assumes nothing beyond IEEE 1800-2017 enums.
package tbc_pkg;

    // Control state of a compaction pass.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } tbc_state_e;

endpackage

// File: rtl/tbc_lane_pick.sv
// Module: tbc_lane_pick
// For one lane, picks the lowest-numbered static warp whose thread is still
// pending and returns its global thread index and a one-hot clear vector.
// Assumes NUM_WARPS >= 2 and LANE < LANES.
module tbc_lane_pick #(
    parameter int NUM_WARPS = 3,
    parameter int LANES     = 4,
    parameter int LANE      = 0,
    parameter int TID_W     = $clog2(NUM_WARPS * LANES)
) (
    input  logic [NUM_WARPS-1:0] pend_col,
    output logic                 hit,
    output logic [TID_W-1:0]     tid,
    output logic [NUM_WARPS-1:0] clr_col
);
    localparam int WI_W = $clog2(NUM_WARPS);

    logic [WI_W-1:0] sel;

    // Priority encoder: lowest pending warp in this lane wins.
    always_comb begin
        sel = '0;
        for (int w = NUM_WARPS - 1; w >= 0; w--) begin
            if (pend_col[w]) sel = WI_W'(w);
        end
    end

    // Slot value and clear vector for the selected thread; empty slot reads 0.
    always_comb begin
        hit     = |pend_col;
        clr_col = '0;
        tid     = '0;
        if (hit) begin
            clr_col[sel] = 1'b1;
            tid = TID_W'(sel) * TID_W'(LANES) + TID_W'(LANE);
        end
    end

endmodule

// File: rtl/tbc_lane_count.sv
// Module: tbc_lane_count
// Counts the set bits of one lane column of the incoming active mask.
// Assumes CNT_W can hold NUM_WARPS.
module tbc_lane_count #(
    parameter int NUM_WARPS = 3,
    parameter int CNT_W     = $clog2(NUM_WARPS + 1)
) (
    input  logic [NUM_WARPS-1:0] col,
    output logic [CNT_W-1:0]     cnt
);
    // Population count of the column.
    always_comb begin
        cnt = '0;
        for (int w = 0; w < NUM_WARPS; w++) begin
            cnt = cnt + CNT_W'(col[w]);
        end
    end

endmodule

// File: rtl/tbc_max_reduce.sv
// Module: tbc_max_reduce
// Returns the largest of LANES per-lane counts (flattened input).
// Assumes all counts share width CNT_W.
module tbc_max_reduce #(
    parameter int LANES = 4,
    parameter int CNT_W = 2
) (
    input  logic [LANES*CNT_W-1:0] cnts,
    output logic [CNT_W-1:0]       max_cnt
);
    // Linear maximum scan across lanes.
    always_comb begin
        max_cnt = '0;
        for (int l = 0; l < LANES; l++) begin
            if (cnts[l*CNT_W +: CNT_W] > max_cnt) max_cnt = cnts[l*CNT_W +: CNT_W];
        end
    end

endmodule

// File: rtl/tbc_compactor.sv
// Module: tbc_compactor (top)
// Lane-preserving thread block compactor. On start (while idle) it loads the
// block-wide active mask, reports the dynamic warp count, then emits one
// dynamic warp per cycle on a valid/ready stream, each lane taking its
// oldest pending thread. pass_done pulses after the final accepted warp.
// Assumes start is raised only once all threads have arrived; start while
// busy is ignored. Output is driven from the pending-mask register, so it is
// stable whenever no warp is accepted.
module tbc_compactor #(
    parameter int NUM_WARPS = 3,
    parameter int LANES     = 4,
    parameter int TID_W     = $clog2(NUM_WARPS * LANES),
    parameter int CNT_W     = $clog2(NUM_WARPS + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [NUM_WARPS*LANES-1:0] act_mask,
    output logic                   busy,
    output logic [CNT_W-1:0]       dw_count,
    output logic                   dw_valid,
    input  logic                   dw_ready,
    output logic [LANES*TID_W-1:0] dw_tids,
    output logic [LANES-1:0]       dw_lane_vld,
    output logic                   pass_done
);
    import tbc_pkg::*;

    localparam int NTHR = NUM_WARPS * LANES;

    tbc_state_e             state_q;
    logic [NTHR-1:0]        pend_q;
    logic [NTHR-1:0]        clr_all;
    logic [NTHR-1:0]        pend_nxt;
    logic [CNT_W-1:0]       cnt_q;
    logic                   done_q;
    logic [LANES*CNT_W-1:0] lane_cnts;
    logic [CNT_W-1:0]       max_cnt;
    logic                   accept;

    // Per-lane pickers on the pending mask and counters on the incoming mask.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [NUM_WARPS-1:0] pcol;
        logic [NUM_WARPS-1:0] acol;
        logic [NUM_WARPS-1:0] ccol;

        for (genvar w = 0; w < NUM_WARPS; w++) begin : g_bit
            assign pcol[w]             = pend_q[w*LANES + l];
            assign acol[w]             = act_mask[w*LANES + l];
            assign clr_all[w*LANES + l] = ccol[w];
        end

        tbc_lane_pick #(
            .NUM_WARPS(NUM_WARPS),
            .LANES    (LANES),
            .LANE     (l),
            .TID_W    (TID_W)
        ) u_pick (
            .pend_col(pcol),
            .hit     (dw_lane_vld[l]),
            .tid     (dw_tids[l*TID_W +: TID_W]),
            .clr_col (ccol)
        );

        tbc_lane_count #(
            .NUM_WARPS(NUM_WARPS),
            .CNT_W    (CNT_W)
        ) u_cnt (
            .col(acol),
            .cnt(lane_cnts[l*CNT_W +: CNT_W])
        );
    end

    tbc_max_reduce #(
        .LANES(LANES),
        .CNT_W(CNT_W)
    ) u_max (
        .cnts   (lane_cnts),
        .max_cnt(max_cnt)
    );

    // Handshake and next pending mask after removing the emitted threads.
    always_comb begin
        accept   = dw_valid && dw_ready;
        pend_nxt = pend_q & ~clr_all;
    end

    // Pass control: load on start, retire one warp per accepted handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pend_q  <= '0;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        pend_q <= act_mask;
                        cnt_q  <= max_cnt;
                        if (|act_mask) state_q <= ST_EMIT;
                        else           done_q  <= 1'b1;
                    end
                end
                ST_EMIT: begin
                    if (accept) begin
                        pend_q <= pend_nxt;
                        if (pend_nxt == '0) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Output status.
    always_comb begin
        busy      = (state_q == ST_EMIT);
        dw_valid  = (state_q == ST_EMIT);
        dw_count  = cnt_q;
        pass_done = done_q;
    end

endmodule

// File: rtl/tbc_compactor_chk.sv
// Module: tbc_compactor_chk
// Property checker for tbc_compactor, attached with bind below. Observes
// ports only. Assumes synchronous active-low reset.
module tbc_compactor_chk #(
    parameter int NUM_WARPS = 3,
    parameter int LANES     = 4,
    parameter int TID_W     = $clog2(NUM_WARPS * LANES),
    parameter int CNT_W     = $clog2(NUM_WARPS + 1)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   start,
    input logic                   busy,
    input logic [CNT_W-1:0]       dw_count,
    input logic                   dw_valid,
    input logic                   dw_ready,
    input logic [LANES*TID_W-1:0] dw_tids,
    input logic [LANES-1:0]       dw_lane_vld,
    input logic                   pass_done
);
    // R7: presented warp holds under backpressure.
    a_r7_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (dw_valid && !dw_ready) |=> (dw_valid && $stable(dw_tids) && $stable(dw_lane_vld)));

    // R8: done is a single-cycle pulse.
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pass_done |=> !pass_done);

    // R8: no warp is presented while done is high.
    a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        pass_done |-> !dw_valid);

    // R10: every presented warp has a valid lane.
    a_r10_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        dw_valid |-> (dw_lane_vld != '0));

    // R10: lane set shrinks or stays between consecutive warps.
    a_r10_subset: assert property (@(posedge clk) disable iff (!rst_n)
        (dw_valid && dw_ready) |=> (!dw_valid || ((dw_lane_vld & ~$past(dw_lane_vld)) == '0)));

    // R9: a start during a pass leaves the count unchanged.
    a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(dw_count));

    for (genvar l = 0; l < LANES; l++) begin : g_slot
        // R11: empty slots read zero.
        a_r11_empty_slot: assert property (@(posedge clk) disable iff (!rst_n)
            (dw_valid && !dw_lane_vld[l]) |-> (dw_tids[l*TID_W +: TID_W] == '0));

        // R2: a valid slot carries a thread of its own lane.
        a_r2_home_lane: assert property (@(posedge clk) disable iff (!rst_n)
            (dw_valid && dw_lane_vld[l]) |-> ((int'(dw_tids[l*TID_W +: TID_W]) % LANES) == l));
    end

endmodule

bind tbc_compactor tbc_compactor_chk #(
    .NUM_WARPS(NUM_WARPS),
    .LANES    (LANES),
    .TID_W    (TID_W),
    .CNT_W    (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .dw_count   (dw_count),
    .dw_valid   (dw_valid),
    .dw_ready   (dw_ready),
    .dw_tids    (dw_tids),
    .dw_lane_vld(dw_lane_vld),
    .pass_done  (pass_done)
);

// File: tb/tb_tbc_compactor.sv
module tb_tbc_compactor;
    localparam int CLK_PERIOD = 10;
    localparam int NW    = 3;
    localparam int NL    = 4;
    localparam int NT    = NW * NL;
    localparam int TW    = $clog2(NT);
    localparam int CW    = $clog2(NW + 1);
    localparam int LIMIT = 100000;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [NT-1:0]  act_mask = '0;
    logic           busy;
    logic [CW-1:0]  dw_count;
    logic           dw_valid;
    logic           dw_ready = 1'b0;
    logic [NL*TW-1:0] dw_tids;
    logic [NL-1:0]  dw_lane_vld;
    logic           pass_done;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tbc_compactor #(.NUM_WARPS(NW), .LANES(NL)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .act_mask(act_mask),
        .busy(busy), .dw_count(dw_count), .dw_valid(dw_valid),
        .dw_ready(dw_ready), .dw_tids(dw_tids), .dw_lane_vld(dw_lane_vld),
        .pass_done(pass_done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Thread index of lane l's k-th active thread, or -1 if none.
    function automatic int exp_tid(logic [NT-1:0] m, int k, int l);
        int seen = 0;
        for (int w = 0; w < NW; w++) begin
            if (m[w*NL + l]) begin
                if (seen == k) return w*NL + l;
                seen++;
            end
        end
        return -1;
    endfunction

    // Largest per-lane active count.
    function automatic int exp_count(logic [NT-1:0] m);
        int best = 0;
        for (int l = 0; l < NL; l++) begin
            int c = 0;
            for (int w = 0; w < NW; w++) c += int'(m[w*NL + l]);
            if (c > best) best = c;
        end
        return best;
    endfunction

    // Compare the presented warp against expected warp k.
    task automatic check_warp(input logic [NT-1:0] m, input int k, input string req);
        check(dw_valid == 1'b1, {req, " valid"}, int'(dw_valid), 1);
        for (int l = 0; l < NL; l++) begin
            int e = exp_tid(m, k, l);
            int a = int'(dw_tids[l*TW +: TW]);
            if (e < 0) begin
                check(dw_lane_vld[l] == 1'b0, "R11 empty lane bit", int'(dw_lane_vld[l]), 0);
                check(a == 0, "R11 empty slot zero", a, 0);
            end else begin
                check(dw_lane_vld[l] == 1'b1, "R3 lane valid", int'(dw_lane_vld[l]), 1);
                check(a == e, {req, " R2 slot tid"}, a, e);
            end
        end
    endtask

    // Run one pass; ready_pct is the chance of ready per cycle; poke issues
    // a stray start during a stall (R9).
    task automatic run_pass(input logic [NT-1:0] m, input int ready_pct, input bit poke, input string req);
        int n = exp_count(m);
        int k = 0;
        bit poked = 1'b0;
        @(negedge clk);
        start = 1'b1; act_mask = m; dw_ready = 1'b0;
        @(negedge clk);
        start = 1'b0;
        check(int'(dw_count) == n, "R4 warp count", int'(dw_count), n);
        if (n == 0) begin
            check(pass_done == 1'b1, "R6 done on empty", int'(pass_done), 1);
            check(dw_valid == 1'b0, "R6 no warp", int'(dw_valid), 0);
            check(busy == 1'b0, "R6 not busy", int'(busy), 0);
            @(negedge clk);
            check(pass_done == 1'b0, "R8 pulse ends", int'(pass_done), 0);
            return;
        end
        while (k < n) begin
            bit r;
            check_warp(m, k, req);
            check(pass_done == 1'b0, "R8 no early done", int'(pass_done), 0);
            r = (($urandom % 100) < ready_pct);
            if (poke && !poked && !r) begin
                start = 1'b1; act_mask = ~m; poked = 1'b1;
            end else begin
                start = 1'b0;
            end
            dw_ready = r;
            @(negedge clk);
            start = 1'b0;
            if (r) k++;
            if (poked) check(int'(dw_count) == n, "R9 count kept", int'(dw_count), n);
        end
        dw_ready = 1'b0;
        check(pass_done == 1'b1, "R8 done after last", int'(pass_done), 1);
        check(dw_valid == 1'b0, "R8 idle after last", int'(dw_valid), 0);
        check(busy == 1'b0, "R8 busy low", int'(busy), 0);
        @(negedge clk);
        check(pass_done == 1'b0, "R8 pulse ends", int'(pass_done), 0);
        check(int'(dw_count) == n, "R4 count held", int'(dw_count), n);
    endtask

    // Watchdog: an expired run is a failed check and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > LIMIT && !finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, LIMIT);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240607));
        repeat (3) @(negedge clk);
        check(dw_valid == 1'b0, "R1 reset valid", int'(dw_valid), 0);
        check(pass_done == 1'b0, "R1 reset done", int'(pass_done), 0);
        check(busy == 1'b0, "R1 reset busy", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(dw_valid == 1'b0, "R1 idle after reset", int'(dw_valid), 0);

        // Directed: worked example one, threads {0,1,4,6,7,10,11}.
        run_pass(12'hCD3, 100, 1'b0, "R3 case A");
        // Directed: worked example two, threads {2,3,5,8,9}.
        run_pass(12'h32C, 60, 1'b0, "R3 case B");
        // Directed: full mask reproduces static warps (R5).
        run_pass({NT{1'b1}}, 100, 1'b0, "R5 full");
        // Directed: empty mask (R6).
        run_pass('0, 100, 1'b0, "R6 empty");
        // Directed: one lane only, deepest column.
        run_pass(12'h111, 50, 1'b1, "R4 single lane");
        // Directed: single thread in last warp, heavy stalls (R7, R9).
        run_pass(12'h800, 20, 1'b1, "R7 stall");

        // Random passes: dense and sparse masks, varied backpressure.
        for (int i = 0; i < 60; i++) begin
            logic [NT-1:0] m = NT'($urandom);
            if (i % 3 == 1) m = m & NT'($urandom);
            run_pass(m, 30 + int'($urandom % 71), (i % 4 == 0), "R3 random");
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule